// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out the call and return instructions of a small 8-bit microcontroller core. A call saves the address of the instruction after it on a downward-growing stack in data SRAM, one byte per cycle, and hands the core a new program counter. A return reads the saved bytes back and hands the restored address to the core. The interrupt-return form also raises a one-cycle request to set the global interrupt enable, bit 7 of the status register.

The 16-bit stack pointer sits in two byte registers that software reads and writes over an I/O port. Software sets it to the top of SRAM before the first call. The core presents an instruction with `instrValid` while `busy` is low and takes the new program counter in the cycle that `pcLoad` is high. SRAM reads are synchronous: data for a read strobed in one cycle arrives on `memRdata` in the next.

Top module: `callstk_top`

## Requirements
- R1: Only five instruction words are accepted: relative call (bits 15:12 = 1101), indirect call (0x9509), long call (bits 15:9 = 1001010 and bits 3:1 = 111), return (0x9508) and interrupt return (0x9518). Any other word presented while idle leaves `busy` low and makes no SRAM access.
- R2: I/O address 0x3D holds the stack pointer low byte and 0x3E the high byte. A write lands on the clock edge and is visible on `ioRdata` in the next cycle. The stack pointer resets to 0x0000.
- R3: A relative call with signed 12-bit offset k in bits 11:0 takes 3 cycles counted from the accept cycle. Cycle 2 writes byte 7:0 of PC+1 at SP. Cycle 3 writes byte 15:8 at SP-1 and pulses `pcLoad` with PC+k+1 (modulo 2^16). SP ends 2 lower.
- R4: An indirect call behaves like R3 in timing and stack writes, with target taken from the Z input.
- R5: A long call takes 4 cycles. Its 22-bit absolute target is {word bits 8:4, word bit 0, second word}, truncated to the PC width. The saved address is PC+2, written low byte first in cycles 3 and 4, and `pcLoad` pulses in cycle 4.
- R6: A return takes 4 cycles. Cycle 2 reads SP+1 (high byte) and cycle 3 reads SP+2 (low byte). Cycle 4 pulses `pcLoad` with the restored address. SP ends 2 higher. Calls and returns nest last-in first-out.
- R7: An interrupt return is a return that also pulses `iFlagSet` in its `pcLoad` cycle. No other instruction ever raises `iFlagSet`.
- R8: `busy` is low after reset and high from the cycle after acceptance until the sequence ends. An instruction presented while `busy` is high is ignored.
- R9: I/O writes to the stack pointer bytes are ignored while a sequence runs or is being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction presented |
| instrWord | input | 16 | First instruction word |
| instrWord2 | input | 16 | Second word (long call target bits 15:0) |
| pcIn | input | PcW | Address of the presented instruction |
| zIn | input | 16 | Z pointer for the indirect call |
| busy | output | 1 | Sequence in progress |
| pcLoad | output | 1 | New program counter valid this cycle |
| pcOut | output | PcW | New program counter |
| iFlagSet | output | 1 | Set global interrupt enable |
| memWe | output | 1 | SRAM byte write strobe |
| memRe | output | 1 | SRAM byte read strobe |
| memAddr | output | 16 | SRAM byte address |
| memWdata | output | 8 | SRAM write data |
| memRdata | input | 8 | SRAM read data, one cycle after `memRe` |
| ioAddr | input | 6 | I/O register address |
| ioWe | input | 1 | I/O write strobe |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data for the stack pointer bytes |

## Verification
The assertions assume `memRdata` carries the byte addressed by the previous cycle's read strobe. They assume `rstN` is held low for at least one edge before the first instruction. They take no position on stack pointer values that wrap through zero. The bench's SRAM model returns data one cycle after a read, as the block requires. It sets the stack pointer well inside that model's range before any call. Every instruction word it presents is fixed and either valid or one it expects to be ignored.

// File: rtl/callstk_pkg.sv
package callstk_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_RCALL = 3'd1,
    OP_ICALL = 3'd2,
    OP_LCALL = 3'd3,
    OP_RET   = 3'd4,
    OP_RETI  = 3'd5
  } op_e;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic       latch;    // capture target and return address
    op_e        op;       // decoded kind, valid with latch
    logic       pushEn;   // write one byte at SP, then SP-1
    logic       popEn;    // read one byte at SP+1, then SP+1
    logic       capByte;  // shift read data into the pop buffer
    logic [1:0] byteIdx;  // return-address byte being written
    logic       selRet;   // pcOut from popped bytes
    logic       ioOpen;   // I/O writes to SP permitted
  } stb_t;

  localparam int unsigned LONG_W = 22;

endpackage

// File: rtl/callstk_decode.sv
module callstk_decode
  import callstk_pkg::*;
(
  input  logic [15:0] instrWord,
  output op_e         op
);

  always_comb begin
    if (instrWord[15:12] == 4'b1101)
      op = OP_RCALL;
    else if (instrWord == 16'h9509)
      op = OP_ICALL;
    else if (instrWord == 16'h9508)
      op = OP_RET;
    else if (instrWord == 16'h9518)
      op = OP_RETI;
    else if (instrWord[15:9] == 7'b1001010 && instrWord[3:1] == 3'b111)
      op = OP_LCALL;
    else
      op = OP_NONE;
  end

endmodule

// File: rtl/callstk_ctrl.sv
module callstk_ctrl
  import callstk_pkg::*;
#(
  parameter int unsigned PcBytes = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic instrValid,
  input  op_e  op,
  output stb_t stb,
  output logic busy,
  output logic pcLoad,
  output logic iFlagSet
);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH2, S_PUSH, S_POP, S_DONE
  } state_e;

  localparam logic [1:0] LastIdx = 2'(PcBytes - 1);

  state_e     state, nextState;
  logic [1:0] cnt;
  logic       retiQ;
  logic       accept;
  logic       lastByte;

  assign accept   = (state == S_IDLE) && instrValid && (op != OP_NONE);
  assign lastByte = (cnt == LastIdx);
  assign busy     = (state != S_IDLE);

  always_comb begin
    stb       = '0;
    stb.op    = op;
    nextState = state;
    pcLoad    = 1'b0;
    iFlagSet  = 1'b0;
    unique case (state)
      S_IDLE: begin
        stb.ioOpen = !accept;
        if (accept) begin
          stb.latch = 1'b1;
          unique case (op)
            OP_RCALL, OP_ICALL: nextState = S_PUSH;
            OP_LCALL:           nextState = S_FETCH2;
            OP_RET, OP_RETI:    nextState = S_POP;
            default:            nextState = S_IDLE;
          endcase
        end
      end
      S_FETCH2: nextState = S_PUSH;
      S_PUSH: begin
        stb.pushEn  = 1'b1;
        stb.byteIdx = cnt;
        if (lastByte) begin
          pcLoad    = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_POP: begin
        stb.popEn   = 1'b1;
        stb.capByte = (cnt != 2'd0);
        if (lastByte) nextState = S_DONE;
      end
      S_DONE: begin
        stb.selRet = 1'b1;
        pcLoad     = 1'b1;
        iFlagSet   = retiQ;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= 2'd0;
      retiQ <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) cnt <= 2'd0;
      else if (state == S_PUSH || state == S_POP) cnt <= cnt + 2'd1;
      if (accept) retiQ <= (op == OP_RETI);
    end
  end

  // R8: an accepted instruction makes the block busy next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy && op != OP_NONE) |=> busy);

  // R1: an unknown word leaves the block idle
  a_r1_ignore_unknown: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy && op == OP_NONE) |=> !busy);

  // R7: interrupt-enable request only with a program counter load
  a_r7_flag_with_load: assert property (@(posedge clk) disable iff (!rstN)
    iFlagSet |-> pcLoad);

  // R6: a restored address follows stack reads
  a_r6_load_after_pops: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && stb.selRet) |-> $past(stb.popEn));

endmodule

// File: rtl/callstk_dpath.sv
module callstk_dpath
  import callstk_pkg::*;
#(
  parameter int unsigned PcW      = 16,
  parameter int unsigned PcBytes  = 2,
  parameter logic [15:0] ResetSp  = 16'h0000,
  parameter logic [5:0]  SpLoAddr = 6'h3D,
  parameter logic [5:0]  SpHiAddr = 6'h3E
) (
  input  logic           clk,
  input  logic           rstN,
  input  stb_t           stb,
  input  logic [15:0]    instrWord,
  input  logic [15:0]    instrWord2,
  input  logic [PcW-1:0] pcIn,
  input  logic [15:0]    zIn,
  input  logic [5:0]     ioAddr,
  input  logic           ioWe,
  input  logic [7:0]     ioWdata,
  output logic [7:0]     ioRdata,
  output logic [15:0]    memAddr,
  output logic [7:0]     memWdata,
  input  logic [7:0]     memRdata,
  output logic [PcW-1:0] pcOut
);

  localparam int unsigned PadW = PcBytes * 8;
  localparam int unsigned BufW = (PcBytes - 1) * 8;
  localparam int unsigned IdxW = (PcBytes > 2) ? 2 : 1;

  logic [15:0]     spReg;
  logic [PadW-1:0] retQ;
  logic [PcW-1:0]  targetQ;
  logic [BufW-1:0] popBuf;
  logic [PadW-1:0] popFull;
  logic [7:0]      retBytes [PcBytes];
  logic [PcW-1:0]  relOff;
  logic [LONG_W-1:0] longTarget;

  // stack pointer: stack moves first, software writes only when open
  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg <= ResetSp;
    end else if (stb.pushEn) begin
      spReg <= spReg - 16'd1;
    end else if (stb.popEn) begin
      spReg <= spReg + 16'd1;
    end else if (ioWe && stb.ioOpen) begin
      if (ioAddr == SpLoAddr) spReg[7:0]  <= ioWdata;
      if (ioAddr == SpHiAddr) spReg[15:8] <= ioWdata;
    end
  end

  always_comb begin
    if (ioAddr == SpLoAddr)      ioRdata = spReg[7:0];
    else if (ioAddr == SpHiAddr) ioRdata = spReg[15:8];
    else                         ioRdata = 8'h00;
  end

  // target and return address captured on accept
  assign relOff     = {{(PcW-12){instrWord[11]}}, instrWord[11:0]};
  assign longTarget = {instrWord[8:4], instrWord[0], instrWord2};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retQ    <= '0;
      targetQ <= '0;
    end else if (stb.latch) begin
      retQ <= PadW'(pcIn) + ((stb.op == OP_LCALL) ? PadW'(2) : PadW'(1));
      unique case (stb.op)
        OP_RCALL: targetQ <= pcIn + relOff + PcW'(1);
        OP_ICALL: targetQ <= PcW'(zIn);
        OP_LCALL: targetQ <= PcW'(longTarget);
        default:  targetQ <= targetQ;
      endcase
    end
  end

  // return address split into bytes, low byte first
  for (genvar b = 0; b < PcBytes; b++) begin : g_bytes
    assign retBytes[b] = retQ[b*8 +: 8];
  end

  assign memWdata = retBytes[stb.byteIdx[IdxW-1:0]];
  assign memAddr  = stb.popEn ? (spReg + 16'd1) : spReg;

  // popped bytes arrive high first; the last one is used directly
  if (PcBytes == 2) begin : g_buf2
    always_ff @(posedge clk) begin
      if (!rstN)            popBuf <= '0;
      else if (stb.capByte) popBuf <= memRdata;
    end
  end else begin : g_bufn
    always_ff @(posedge clk) begin
      if (!rstN)            popBuf <= '0;
      else if (stb.capByte) popBuf <= {popBuf[BufW-9:0], memRdata};
    end
  end

  assign popFull = {popBuf, memRdata};
  assign pcOut   = stb.selRet ? popFull[PcW-1:0] : targetQ;

  // R3: every pushed byte lowers the stack pointer by one
  a_r3_push_dec: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushEn |=> (spReg == $past(spReg) - 16'd1));

  // R6: every popped byte raises the stack pointer by one
  a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rstN)
    stb.popEn |=> (spReg == $past(spReg) + 16'd1));

  // R9: software writes while a sequence runs leave SP alone
  a_r9_io_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (ioWe && !stb.ioOpen && !stb.pushEn && !stb.popEn) |=> $stable(spReg));

endmodule

// File: rtl/callstk_top.sv
module callstk_top
  import callstk_pkg::*;
#(
  parameter int unsigned PcW      = 16,
  parameter logic [15:0] ResetSp  = 16'h0000,
  parameter logic [5:0]  SpLoAddr = 6'h3D,
  parameter logic [5:0]  SpHiAddr = 6'h3E
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           instrValid,
  input  logic [15:0]    instrWord,
  input  logic [15:0]    instrWord2,
  input  logic [PcW-1:0] pcIn,
  input  logic [15:0]    zIn,
  output logic           busy,
  output logic           pcLoad,
  output logic [PcW-1:0] pcOut,
  output logic           iFlagSet,
  output logic           memWe,
  output logic           memRe,
  output logic [15:0]    memAddr,
  output logic [7:0]     memWdata,
  input  logic [7:0]     memRdata,
  input  logic [5:0]     ioAddr,
  input  logic           ioWe,
  input  logic [7:0]     ioWdata,
  output logic [7:0]     ioRdata
);

  localparam int unsigned PcBytes = (PcW + 7) / 8;

  op_e  op;
  stb_t stb;

  callstk_decode u_decode (
    .instrWord (instrWord),
    .op        (op)
  );

  callstk_ctrl #(.PcBytes(PcBytes)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .op         (op),
    .stb        (stb),
    .busy       (busy),
    .pcLoad     (pcLoad),
    .iFlagSet   (iFlagSet)
  );

  callstk_dpath #(
    .PcW      (PcW),
    .PcBytes  (PcBytes),
    .ResetSp  (ResetSp),
    .SpLoAddr (SpLoAddr),
    .SpHiAddr (SpHiAddr)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .instrWord  (instrWord),
    .instrWord2 (instrWord2),
    .pcIn       (pcIn),
    .zIn        (zIn),
    .ioAddr     (ioAddr),
    .ioWe       (ioWe),
    .ioWdata    (ioWdata),
    .ioRdata    (ioRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata),
    .pcOut      (pcOut)
  );

  assign memWe = stb.pushEn;
  assign memRe = stb.popEn;

endmodule

// File: tb/callstk_tb.sv
module callstk_top_tb_top;

  localparam int ClkPeriod = 10;
  localparam int K_WR = 1, K_RD = 2, K_PC = 3;
  localparam int OP_NONE = 0, OP_RCALL = 1, OP_ICALL = 2, OP_LCALL = 3, OP_RET = 4, OP_RETI = 5;

  typedef struct {
    int    kind;
    int    addr;
    int    data;
    int    iflag;
    int    cyc;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0, instrWord2 = '0, pcIn = '0, zIn = '0;
  logic        busy, pcLoad, iFlagSet, memWe, memRe;
  logic [15:0] pcOut, memAddr;
  logic [7:0]  memWdata, memRdata, ioRdata;
  logic [5:0]  ioAddr = 6'h3D;
  logic        ioWe = 1'b0;
  logic [7:0]  ioWdata = '0;

  int checks = 0, errors = 0, cycleCnt = 0;
  bit finished = 0;
  exp_t q[$];
  logic [15:0] shadow[$];
  logic [15:0] mSp;
  logic [7:0]  mem [0:1023];
  logic [7:0]  rdReg = '0;

  callstk_top dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .instrWord2(instrWord2), .pcIn(pcIn), .zIn(zIn), .busy(busy),
    .pcLoad(pcLoad), .pcOut(pcOut), .iFlagSet(iFlagSet), .memWe(memWe),
    .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .ioAddr(ioAddr), .ioWe(ioWe), .ioWdata(ioWdata), .ioRdata(ioRdata)
  );

  always #(ClkPeriod/2) clk = ~clk;

  // SRAM model with one-cycle read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr[9:0]] <= memWdata;
    if (memRe) rdReg <= mem[memAddr[9:0]];
  end
  assign memRdata = rdReg;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt == 20000 && !finished) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic pushExp(input int kind, input int addr, input int data,
                         input int iflag, input int cyc, input string req);
    exp_t e;
    e.kind = kind; e.addr = addr; e.data = data;
    e.iflag = iflag; e.cyc = cyc; e.req = req;
    q.push_back(e);
  endtask

  task automatic observe(input int kind, input int addr, input int data, input int iflag);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R1 unexpected event", kind, 0);
      return;
    end
    e = q.pop_front();
    check(e.kind == kind, e.req, kind, e.kind);
    check(e.addr == addr && e.data == data && e.iflag == iflag,
          e.req, addr * 65536 + data + iflag * 256, e.addr * 65536 + e.data + e.iflag * 256);
    check(e.cyc == cycleCnt, e.req, cycleCnt, e.cyc);
  endtask

  // monitor: compare design events against the scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (memWe) observe(K_WR, int'(memAddr), int'(memWdata), 0);
      if (memRe) observe(K_RD, int'(memAddr), 0, 0);
      if (pcLoad) observe(K_PC, int'(pcOut), 0, int'(iFlagSet));
      if (iFlagSet && !pcLoad) check(1'b0, "R7 stray flag", 1, 0);
    end
  end

  // driver: present one instruction and queue what it must produce
  task automatic issue(input int kind, input logic [15:0] w, input logic [15:0] w2,
                       input logic [15:0] pc, input logic [15:0] z,
                       input bit stray, input bit ioStray, input string req);
    int n;
    int base;
    logic [15:0] tgt, ret;
    @(negedge clk);
    instrValid = 1'b1; instrWord = w; instrWord2 = w2; pcIn = pc; zIn = z;
    n = cycleCnt;
    if (kind == OP_RCALL || kind == OP_ICALL || kind == OP_LCALL) begin
      base = (kind == OP_LCALL) ? n + 2 : n + 1;
      ret  = (kind == OP_LCALL) ? pc + 16'd2 : pc + 16'd1;
      if (kind == OP_RCALL) tgt = pc + {{4{w[11]}}, w[11:0]} + 16'd1;
      else if (kind == OP_ICALL) tgt = z;
      else tgt = w2;
      pushExp(K_WR, int'(mSp), int'(ret[7:0]), 0, base, req);
      pushExp(K_WR, int'(mSp - 16'd1), int'(ret[15:8]), 0, base + 1, req);
      pushExp(K_PC, int'(tgt), 0, 0, base + 1, req);
      shadow.push_back(ret);
      mSp = mSp - 16'd2;
    end else if (kind == OP_RET || kind == OP_RETI) begin
      pushExp(K_RD, int'(mSp + 16'd1), 0, 0, n + 1, req);
      pushExp(K_RD, int'(mSp + 16'd2), 0, 0, n + 2, req);
      pushExp(K_PC, int'(shadow.pop_back()), 0, (kind == OP_RETI) ? 1 : 0, n + 3, req);
      mSp = mSp + 16'd2;
    end
    @(negedge clk);
    if (kind == OP_NONE) check(busy == 1'b0, req, busy, 0);
    else check(busy == 1'b1, "R8 busy after accept", busy, 1);
    instrValid = stray;
    instrWord  = 16'h9508;
    if (ioStray) begin
      ioWe = 1'b1; ioAddr = 6'h3D; ioWdata = 8'h00;
    end
    @(negedge clk);
    instrValid = 1'b0;
    ioWe = 1'b0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, req, q.size(), 0);
    check(busy == 1'b0, "R8 idle after sequence", busy, 0);
    q.delete();
  endtask

  task automatic checkSp(input logic [15:0] expv, input string req);
    logic [15:0] got;
    @(negedge clk);
    ioAddr = 6'h3D; #1 got[7:0] = ioRdata;
    ioAddr = 6'h3E; #1 got[15:8] = ioRdata;
    check(got == expv, req, got, expv);
  endtask

  task automatic setSp(input logic [15:0] v);
    @(negedge clk);
    ioWe = 1'b1; ioAddr = 6'h3D; ioWdata = v[7:0];
    @(negedge clk);
    #1 check(ioRdata == v[7:0], "R2 low byte next cycle", ioRdata, v[7:0]);
    ioAddr = 6'h3E; ioWdata = v[15:8];
    @(negedge clk);
    ioWe = 1'b0;
    mSp = v;
  endtask

  initial begin
    mSp = 16'h0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && pcLoad == 1'b0, "R8 reset idle", busy, 0);
    check(memWe == 1'b0 && memRe == 1'b0 && iFlagSet == 1'b0, "R1 reset quiet", memWe, 0);
    checkSp(16'h0000, "R2 reset value");

    setSp(16'h03FF);
    checkSp(16'h03FF, "R2 readback");

    // R3 relative call, with a stray return presented while busy (R8)
    issue(OP_RCALL, 16'hD010, 16'h0, 16'h0100, 16'h0, 1'b1, 1'b0, "R3 relative call");
    checkSp(16'h03FD, "R3 sp after call");
    // R4 indirect call, with an I/O write during the sequence (R9)
    issue(OP_ICALL, 16'h9509, 16'h0, 16'h0200, 16'h1234, 1'b0, 1'b1, "R4 indirect call");
    checkSp(16'h03FB, "R9 sp unchanged by blocked write");
    // R5 long call
    issue(OP_LCALL, 16'h940E, 16'h4567, 16'h0300, 16'h0, 1'b0, 1'b0, "R5 long call");
    checkSp(16'h03F9, "R5 sp after call");
    // R6 / R7 nested returns in LIFO order
    issue(OP_RET, 16'h9508, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R6 return");
    issue(OP_RETI, 16'h9518, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R7 interrupt return");
    issue(OP_RET, 16'h9508, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0, "R6 return nested");
    checkSp(16'h03FF, "R6 sp restored");
    // R3 most negative offset with wrap
    issue(OP_RCALL, 16'hD800, 16'h0, 16'h0010, 16'h0, 1'b0, 1'b0, "R3 negative offset");
    issue(OP_RET, 16'h9508, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R6 return after wrap");
    // R1 words that must be ignored
    issue(OP_NONE, 16'h0000, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R1 ignore zero word");
    issue(OP_NONE, 16'hF001, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R1 ignore branch word");
    issue(OP_NONE, 16'h940C, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, "R1 ignore jump word");
    checkSp(16'h03FF, "R1 sp untouched");

    finished = 1;
    summary();
    $finish;
  end

endmodule